// File: doc/BRIEF.md
# Serial Flash Identity and Geometry Probe

This block finds out which serial flash is attached to an SPI port, and how that flash is set up. After reset it starts on its own. After that it runs again on each `start` pulse. Each run has two chip-select sessions. The first session sends the identification opcode and reads the identity bytes. The second session sends the status opcode and reads one status byte. The block decodes a size class from each session and checks that the two agree. It then reports the size class, the page-size mode, and whether an extended-information byte was present. Each result is marked either valid or flagged as an error. The flash may answer with either of two identity revisions: an older one with no extended information, and a newer one that appends a single extended byte.

The sequencer moves through these states:
- `ST_IDLE` to `ST_ID_OP` on the boot request or on `start`.
- `ST_ID_OP` to `ST_ID_RX` once the opcode byte is sent.
- `ST_ID_RX` reads four bytes. After the length byte it goes to `ST_ID_EXT` if the length is 01h, and to `ST_GAP` otherwise.
- `ST_ID_EXT` to `ST_GAP` after the extended byte.
- `ST_GAP` holds chip select high for a fixed count, then goes to `ST_ST_OP`.
- `ST_ST_OP` to `ST_ST_RX`.
- `ST_ST_RX` to `ST_FINISH` after one status byte.
- `ST_FINISH` publishes the results and returns to `ST_IDLE`.

A shared byte engine drives SCK and MOSI and samples MISO.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is held, `spi_cs_n` is 1, `spi_sck` is 0, and `valid`, `busy` and `done` are 0. After reset is released, a probe run starts without any `start` pulse.
- R2: SPI mode 0 is used. SCK idles low. MOSI is sent MSB first and is stable while SCK is high. MISO is sampled on the rising SCK edge.
- R3: The first session sends opcode 9Fh and then reads the response bytes. The second response byte (index 1) is the density code: 22h means 1 Mbit and 23h means 2 Mbit. Any other value is unknown.
- R4: The fourth response byte (index 3) is the extended length. If it is 01h, one more byte is clocked in and ignored, and `has_ext` is 1 (48 SCK cycles in the session). If it is 00h, the session ends after the length byte (40 SCK cycles) and `has_ext` is 0.
- R5: If the length byte is neither 00h nor 01h, the session ends after the length byte, `unsupported_err` is 1 and `valid` is 0.
- R6: Chip select goes high between the two sessions. The second session sends opcode D7h and clocks exactly one status byte (16 SCK cycles in total), then chip select goes high.
- R7: `size_code` is decoded from status bits [5:2]: 0011→0 (1 Mbit), 0101→1 (2 Mbit), 0111→2 (4 Mbit), 1001→3 (8 Mbit), 1011→4 (16 Mbit). Any other value gives 7.
- R8: `page_pow2` equals status bit 0. A value of 1 means 256-byte pages and 0 means 264-byte pages.
- R9: `mismatch_err` is 1 and `valid` is 0 when the identity density and the status size disagree, or when either one is unknown. Status bits 7, 6 and 1 have no effect on any output.
- R10: A `start` pulse while `busy` is high is ignored. `valid` drops when a run begins. All results hold their values from `done` until the next run.
- R11: `done` is a one-cycle pulse. It is issued in the first cycle after the run in which `busy` is low, and it coincides with the results updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new probe run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when results update |
| valid | output | 1 | Results are consistent and supported |
| size_code | output | 3 | Decoded size class from the status byte |
| page_pow2 | output | 1 | 1 = 256-byte pages, 0 = 264-byte pages |
| has_ext | output | 1 | The extended-information byte was present |
| mismatch_err | output | 1 | The density codes disagree or are unknown |
| unsupported_err | output | 1 | The extended length byte is not 00h or 01h |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The bench attaches a flash model that records the opcode and the number of SCK cycles in every chip-select session, so session lengths are checked at the pins.

Three identity layouts are covered: no extended byte, one extended byte, and an illegal length. A design that always read a fixed number of bytes would show 40 or 48 cycles where the other count was due.

Status codes for every size class are exercised, including unknown ones, and are paired with both identity revisions. A design that trusted only one of the two sources would claim valid on a conflicting pair.

The bench also drives status bytes with the ready, compare and protect bits set, and puts a distinct second status byte in the model. A design that decoded the wrong bits, or kept reading past the first status byte, would report a different size or a longer session.

A second `start` pulse arrives while a run is in progress. A design that accepted it would open a third session.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_OP,
        ST_ID_RX,
        ST_ID_EXT,
        ST_GAP,
        ST_ST_OP,
        ST_ST_RX,
        ST_FINISH
    } probe_state_t;

    localparam logic [7:0] OP_READ_ID   = 8'h9F;
    localparam logic [7:0] OP_READ_STAT = 8'hD7;
    localparam logic [7:0] ID_DENS_1M   = 8'h22;
    localparam logic [7:0] ID_DENS_2M   = 8'h23;

    localparam logic [2:0] SZ_1M      = 3'd0;
    localparam logic [2:0] SZ_2M      = 3'd1;
    localparam logic [2:0] SZ_4M      = 3'd2;
    localparam logic [2:0] SZ_8M      = 3'd3;
    localparam logic [2:0] SZ_16M     = 3'd4;
    localparam logic [2:0] SZ_UNKNOWN = 3'd7;

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic          active;
    logic [HW-1:0] hc;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            hc      <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                active  <= 1'b1;
                tx_sh   <= tx_byte;
                hc      <= '0;
                bit_idx <= '0;
                sck     <= 1'b0;
            end else if (active) begin
                if (hc == HW'(HALF_CYC - 1)) begin
                    hc <= '0;
                    if (!sck) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck   <= 1'b0;
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        if (bit_idx == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                        end
                    end
                end else begin
                    hc <= hc + HW'(1);
                end
            end
        end
    end

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode
    import flash_id_pkg::*;
(
    input  logic [7:0] dens_byte,
    input  logic [7:0] stat_byte,
    output logic [2:0] id_code,
    output logic [2:0] st_code,
    output logic       st_pow2
);
    always_comb begin
        unique case (dens_byte)
            ID_DENS_1M: id_code = SZ_1M;
            ID_DENS_2M: id_code = SZ_2M;
            default:    id_code = SZ_UNKNOWN;
        endcase
    end

    always_comb begin
        unique case (stat_byte[5:2])
            4'b0011: st_code = SZ_1M;
            4'b0101: st_code = SZ_2M;
            4'b0111: st_code = SZ_4M;
            4'b1001: st_code = SZ_8M;
            4'b1011: st_code = SZ_16M;
            default: st_code = SZ_UNKNOWN;
        endcase
    end

    assign st_pow2 = stat_byte[0];

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_id_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int GAP_CYC  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       valid,
    output logic [2:0] size_code,
    output logic       page_pow2,
    output logic       has_ext,
    output logic       mismatch_err,
    output logic       unsupported_err,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    probe_state_t  state, nxt;
    logic          launch;
    logic [7:0]    tx_sel;
    logic          eng_done;
    logic [7:0]    eng_rx;
    logic [1:0]    byte_idx;
    logic [GW-1:0] gap_cnt;
    logic          boot_pend;
    logic [7:0]    dens_q, len_q, stat_q;
    logic [2:0]    id_code, st_code;
    logic          st_pow2;
    logic          len_ok;

    spi_byte_engine #(.HALF_CYC(HALF_CYC)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .tx_byte (tx_sel),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    flash_id_decode u_decode (
        .dens_byte (dens_q),
        .stat_byte (stat_q),
        .id_code   (id_code),
        .st_code   (st_code),
        .st_pow2   (st_pow2)
    );

    assign len_ok = (len_q == 8'h00) || (len_q == 8'h01);
    assign busy   = (state != ST_IDLE);

    always_comb begin
        nxt    = state;
        launch = 1'b0;
        tx_sel = 8'h00;
        unique case (state)
            ST_IDLE: if (boot_pend || start) begin
                nxt    = ST_ID_OP;
                launch = 1'b1;
                tx_sel = OP_READ_ID;
            end
            ST_ID_OP: if (eng_done) begin
                nxt    = ST_ID_RX;
                launch = 1'b1;
            end
            ST_ID_RX: if (eng_done) begin
                if (byte_idx == 2'd3) begin
                    if (eng_rx == 8'h01) begin
                        nxt    = ST_ID_EXT;
                        launch = 1'b1;
                    end else begin
                        nxt = ST_GAP;
                    end
                end else begin
                    launch = 1'b1;
                end
            end
            ST_ID_EXT: if (eng_done) nxt = ST_GAP;
            ST_GAP: if (gap_cnt == GW'(GAP_CYC - 1)) begin
                nxt    = ST_ST_OP;
                launch = 1'b1;
                tx_sel = OP_READ_STAT;
            end
            ST_ST_OP: if (eng_done) begin
                nxt    = ST_ST_RX;
                launch = 1'b1;
            end
            ST_ST_RX: if (eng_done) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_cs_n        <= 1'b1;
            boot_pend       <= 1'b1;
            byte_idx        <= '0;
            gap_cnt         <= '0;
            dens_q          <= '0;
            len_q           <= '0;
            stat_q          <= '0;
            done            <= 1'b0;
            valid           <= 1'b0;
            size_code       <= SZ_UNKNOWN;
            page_pow2       <= 1'b0;
            has_ext         <= 1'b0;
            mismatch_err    <= 1'b0;
            unsupported_err <= 1'b0;
        end else begin
            spi_cs_n <= (nxt == ST_IDLE) || (nxt == ST_GAP) || (nxt == ST_FINISH);
            done     <= (state == ST_FINISH);
            gap_cnt  <= (state == ST_GAP) ? gap_cnt + GW'(1) : '0;
            if (state == ST_IDLE && launch) begin
                boot_pend <= 1'b0;
                valid     <= 1'b0;
            end
            if (state == ST_ID_OP) byte_idx <= '0;
            if (state == ST_ID_RX && eng_done) begin
                byte_idx <= byte_idx + 2'd1;
                if (byte_idx == 2'd1) dens_q <= eng_rx;
                if (byte_idx == 2'd3) len_q  <= eng_rx;
            end
            if (state == ST_ST_RX && eng_done) stat_q <= eng_rx;
            if (state == ST_FINISH) begin
                mismatch_err    <= (id_code == SZ_UNKNOWN) || (st_code == SZ_UNKNOWN)
                                   || (id_code != st_code);
                unsupported_err <= !len_ok;
                valid           <= len_ok && (id_code != SZ_UNKNOWN) && (id_code == st_code);
                size_code       <= st_code;
                page_pow2       <= st_pow2;
                has_ext         <= (len_q == 8'h01);
            end
        end
    end

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R9
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (!mismatch_err && !unsupported_err));

    // R11
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> ($stable(size_code) && $stable(valid) && $stable(mismatch_err)));

endmodule

// File: tb/flash_id_probe_bench.sv
`timescale 1ns/1ps
module flash_id_probe_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, valid, page_pow2, has_ext, mismatch_err, unsupported_err;
    logic [2:0] size_code;
    logic spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    flash_id_probe u_flash_id_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .valid(valid), .size_code(size_code), .page_pow2(page_pow2),
        .has_ext(has_ext), .mismatch_err(mismatch_err),
        .unsupported_err(unsupported_err), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model
    logic [7:0] id_resp [0:7];
    logic [7:0] st_resp [0:1];
    int sess = 0;
    int seen = 0;
    int cnt = 0;
    logic [7:0] cmd = 8'h00;
    int log_n = 0;
    logic [7:0] log_op [0:3];
    int log_bits [0:3];

    always @(negedge spi_cs_n) sess = sess + 1;

    always @(posedge spi_cs_n) begin
        log_op[log_n % 4]   = cmd;
        log_bits[log_n % 4] = cnt;
        log_n = log_n + 1;
    end

    always @(posedge spi_sck) begin
        if (seen != sess) begin
            seen = sess;
            cnt  = 0;
        end
        if (cnt < 8) cmd = {cmd[6:0], spi_mosi};
        cnt = cnt + 1;
    end

    always @(negedge spi_sck) begin
        if (cnt >= 8) begin
            int k;
            int j;
            logic [7:0] b;
            k = cnt - 8;
            j = k / 8;
            if (cmd == 8'h9F) b = (j < 8) ? id_resp[j] : 8'h00;
            else              b = st_resp[j % 2];
            spi_miso = b[7 - (k % 8)];
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] dens, input logic [7:0] len,
                        input logic [7:0] ext, input logic [7:0] stat);
        id_resp[0] = 8'h1F; id_resp[1] = dens; id_resp[2] = 8'h01; id_resp[3] = len;
        id_resp[4] = ext;   id_resp[5] = 8'h5A; id_resp[6] = 8'h5A; id_resp[7] = 8'h5A;
        st_resp[0] = stat;  st_resp[1] = 8'h24;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t;
        t = 0;
        while (done !== 1'b1 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(req, "done seen", int'(done === 1'b1), 1);
    endtask

    task automatic verify(input string req, input int base,
                          input int e_valid, input int e_size, input int e_pow2,
                          input int e_mm, input int e_uns, input int e_ext, input int e_idbits);
        check("R9",  {req, " valid"}, valid, e_valid);
        check("R7",  {req, " size_code"}, size_code, e_size);
        check("R8",  {req, " page_pow2"}, page_pow2, e_pow2);
        check("R9",  {req, " mismatch_err"}, mismatch_err, e_mm);
        check("R5",  {req, " unsupported_err"}, unsupported_err, e_uns);
        check("R4",  {req, " has_ext"}, has_ext, e_ext);
        check("R6",  {req, " session count"}, log_n - base, 2);
        check("R3",  {req, " id opcode"}, log_op[base % 4], 8'h9F);
        check("R4",  {req, " id session clocks"}, log_bits[base % 4], e_idbits);
        check("R6",  {req, " status opcode"}, log_op[(base + 1) % 4], 8'hD7);
        check("R6",  {req, " status session clocks"}, log_bits[(base + 1) % 4], 16);
        @(negedge clk);
        check("R11", {req, " done width"}, done, 0);
        check("R11", {req, " busy after done"}, busy, 0);
    endtask

    task automatic run_case(input string req, input logic [7:0] dens, input logic [7:0] len,
                            input logic [7:0] ext, input logic [7:0] stat,
                            input int e_valid, input int e_size, input int e_pow2,
                            input int e_mm, input int e_uns, input int e_ext, input int e_idbits);
        int base;
        load(dens, len, ext, stat);
        base = log_n;
        pulse_start();
        wait_done(req);
        verify(req, base, e_valid, e_size, e_pow2, e_mm, e_uns, e_ext, e_idbits);
    endtask

    task automatic test_reset_boot();
        int base;
        load(8'h22, 8'h00, 8'h00, 8'h8C);
        repeat (4) @(negedge clk);
        check("R1", "cs_n in reset", spi_cs_n, 1);
        check("R1", "sck in reset", spi_sck, 0);
        check("R1", "valid in reset", valid, 0);
        check("R1", "busy in reset", busy, 0);
        check("R1", "done in reset", done, 0);
        base = log_n;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "boot run busy", busy, 1);
        wait_done("R1");
        verify("R1 boot old rev", base, 1, 0, 0, 0, 0, 0, 40);
    endtask

    task automatic test_busy_ignore();
        int base;
        load(8'h23, 8'h01, 8'h00, 8'h95);
        base = log_n;
        pulse_start();
        @(negedge clk);
        check("R10", "valid drops at run start", valid, 0);
        repeat (20) @(negedge clk);
        pulse_start();
        wait_done("R10");
        verify("R10 start while busy", base, 1, 1, 1, 0, 0, 1, 48);
        repeat (400) @(negedge clk);
        check("R10", "no extra session", log_n - base, 2);
        check("R10", "still idle", busy, 0);
        check("R10", "size held", size_code, 1);
        check("R10", "valid held", valid, 1);
    endtask

    initial begin
        test_reset_boot();
        run_case("R4 new rev 2M ext", 8'h23, 8'h01, 8'h00, 8'h95, 1, 1, 1, 0, 0, 1, 48);
        run_case("R9 id1M st2M", 8'h22, 8'h00, 8'h00, 8'h94, 0, 1, 0, 1, 0, 0, 40);
        run_case("R3 unknown id", 8'h25, 8'h00, 8'h00, 8'h9C, 0, 2, 0, 1, 0, 0, 40);
        run_case("R7 unknown status", 8'h22, 8'h00, 8'h00, 8'h81, 0, 7, 1, 1, 0, 0, 40);
        run_case("R7 8M status", 8'h22, 8'h00, 8'h00, 8'hA4, 0, 3, 0, 1, 0, 0, 40);
        run_case("R7 16M status", 8'h23, 8'h01, 8'h00, 8'hAC, 0, 4, 0, 1, 0, 1, 48);
        run_case("R5 bad length", 8'h23, 8'h02, 8'h00, 8'h95, 0, 1, 1, 0, 1, 0, 40);
        run_case("R9 other bits ignored", 8'h22, 8'h00, 8'h00, 8'h4E, 1, 0, 0, 0, 0, 0, 40);
        run_case("R8 pow2 1M", 8'h22, 8'h00, 8'h00, 8'h8D, 1, 0, 1, 0, 0, 0, 40);
        test_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule